// File: doc/BRIEF.md
# NAND Bus Cycle Sequencer

This block drives the strobes of an asynchronous NAND flash bus for one access at a time. A request gives a kind (command byte, address byte, data read or data write), the write data, and a flag that forces a byte-wide transfer. The sequencer then runs the access through its phases and drives chip enable, the two latch enables, the write and read strobes, and the data bus. A one-cycle completion pulse follows each access. Read data is captured inside the access and held for the requester.

Two programmable timing words set the phase lengths. The attribute word applies to command and address latch cycles. The memory word applies to data transfers. Every access runs setup, strobe-active wait and hold, in that order. Accesses that drive the bus (command, address, write) first run a bus-release turnaround in which chip enable is already low but the data bus is not yet driven. While the optional wait input is enabled, a busy device stretches the strobe. A read that directly follows a command or address cycle gets a longer setup, so that a minimum latch-enable-to-read-strobe delay is met.

Top module: `nbs_nand_seq`

## Requirements
- R1: After reset chip enable, both strobes are high, the latch enables and all output enables are low, req_ready is 1. Every field of both timing words is 10, and both latch-to-read delays are 15 (16 cycles).
- R2: An accepted access keeps ce_n low for T+S+W+H cycles: turnaround T, then setup S, then strobe-low W, then hold H. done is high for exactly the cycle after the last hold cycle.
- R3: Kind encoding is 0 command, 1 address, 2 read, 3 write. Command and address take their lengths from the attribute word and reads and writes from the memory word. In each word bits [7:0] are setup, [15:8] wait, [23:16] hold and [31:24] turnaround, all counted in cycles. cle is high through a command access, ale through an address access, and never both at once.
- R4: A setup, wait or hold field of 0 gives a phase of 1 cycle.
- R5: A read whose previous access was a command gets a setup of at least cle_re+1 cycles. After an address access the minimum is ale_re+1. After a read or write the setup is not extended.
- R6: Command, address and write accesses spend T cycles (the turnaround field, 0 allowed) with ce_n low and the bus not driven. They then drive the bus from the first setup cycle to the last hold cycle. Reads never drive it. we_n is low during the wait of driving accesses and re_n during the wait of reads.
- R7: With wait_en high, a low rdy on the last wait cycle keeps the strobe low until the first cycle in which rdy is high. With wait_en low, rdy has no effect.
- R8: rd_data takes dq_in at the clock edge that ends the last wait cycle of a read (re_n still low) and holds it until the next read.
- R9: An access is 16 bits wide when bus16 is 1 and req_byte is 0: dq_oe is 2'b11 and all of rd_data is used. Otherwise dq_oe is 2'b01, dq_out[15:8] is 0 and rd_data[15:8] is 0.
- R10: A request is taken only when req_ready is high. req_ready is low from acceptance through the done cycle, and a request raised meanwhile starts no access.
- R11: A configuration write made during an access does not change that access. It applies from the next accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_kind | input | 2 | 0 command, 1 address, 2 read, 3 write |
| req_byte | input | 1 | Force a byte-wide transfer |
| req_wdata | input | 16 | Command, address or write data |
| bus16 | input | 1 | Device bus is 16 bits wide |
| wait_en | input | 1 | Let rdy stretch the strobe |
| rdy | input | 1 | Device ready (low = busy) |
| cfg_we | input | 1 | Load the timing configuration |
| cfg_mem | input | 32 | Memory timing word |
| cfg_att | input | 32 | Attribute timing word |
| cfg_cle_re | input | 4 | Command-latch to read-strobe delay minus one |
| cfg_ale_re | input | 4 | Address-latch to read-strobe delay minus one |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 16 | Data bus out |
| dq_oe | output | 2 | Output enable per byte lane |
| dq_in | input | 16 | Data bus in |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | Access complete pulse |

## Verification
The bench aims at phase fields of zero, where a design without the minimum clamp would hang or skip a strobe. It aims at reads right after command and address cycles, where a missing setup extension shows up as a short ce_n-low count. It holds rdy low past the wait count, with wait_en both high and low. A wrong stall would give a strobe of the wrong length. It changes dq_in at the moment re_n rises, so that a capture one edge late returns the inverted pattern. It also raises requests and configuration writes in the middle of an access. A design that leaks either into the running access shows a second ce_n window or changed phase lengths.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

   typedef enum logic [1:0] {
      K_CMD  = 2'd0,
      K_ADDR = 2'd1,
      K_RD   = 2'd2,
      K_WR   = 2'd3
   } nbs_kind_e;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_TURN  = 3'd1,
      PH_SETUP = 3'd2,
      PH_WAIT  = 3'd3,
      PH_HOLD  = 3'd4,
      PH_DONE  = 3'd5
   } nbs_phase_e;

   function automatic logic kind_drives(input nbs_kind_e k);
      return k != K_RD;
   endfunction

endpackage

// File: rtl/nbs_cfg.sv
module nbs_cfg
   import nbs_pkg::*;
#(
   parameter int FW        = 8,
   parameter int DLYW      = 4,
   parameter int LW        = 8,
   parameter int RST_FIELD = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [4*FW-1:0]   cfg_mem,
   input  logic [4*FW-1:0]   cfg_att,
   input  logic [DLYW-1:0]   cfg_cle_re,
   input  logic [DLYW-1:0]   cfg_ale_re,
   input  nbs_kind_e         req_kind,
   input  logic              acc,
   output logic [LW-1:0]     len_turn,
   output logic [LW-1:0]     len_setup,
   output logic [LW-1:0]     len_wait,
   output logic [LW-1:0]     len_hold
);
   localparam int WW = 4 * FW;

   generate
      if (LW < FW || LW <= DLYW) begin : g_bad_lw
         $error("nbs_cfg: LW too narrow for fields");
      end
   endgenerate

   logic [WW-1:0]   mem_q, att_q, sel_w;
   logic [DLYW-1:0] cle_q, ale_q;
   nbs_kind_e       prev_q;
   logic [LW-1:0]   fld [4];
   logic [LW-1:0]   ext, s_min;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q  <= {4{FW'(RST_FIELD)}};
         att_q  <= {4{FW'(RST_FIELD)}};
         cle_q  <= {DLYW{1'b1}};
         ale_q  <= {DLYW{1'b1}};
         prev_q <= K_WR;
      end else begin
         if (cfg_we) begin
            mem_q <= cfg_mem;
            att_q <= cfg_att;
            cle_q <= cfg_cle_re;
            ale_q <= cfg_ale_re;
         end
         if (acc) prev_q <= req_kind;
      end
   end

   function automatic logic [LW-1:0] at_least_one(input logic [LW-1:0] v);
      return (v == '0) ? LW'(1) : v;
   endfunction

   assign sel_w = (req_kind == K_CMD || req_kind == K_ADDR) ? att_q : mem_q;

   // field 0 setup, 1 wait, 2 hold, 3 bus-release
   generate
      for (genvar i = 0; i < 4; i++) begin : g_fld
         assign fld[i] = LW'(sel_w[i*FW +: FW]);
      end
   endgenerate

   always_comb begin
      ext = '0;
      if (req_kind == K_RD) begin
         if (prev_q == K_CMD)       ext = LW'(cle_q) + LW'(1);
         else if (prev_q == K_ADDR) ext = LW'(ale_q) + LW'(1);
      end
      s_min = at_least_one(fld[0]);
   end

   assign len_setup = (ext > s_min) ? ext : s_min;
   assign len_wait  = at_least_one(fld[1]);
   assign len_hold  = at_least_one(fld[2]);
   assign len_turn  = kind_drives(req_kind) ? fld[3] : '0;

endmodule

// File: rtl/nbs_seq.sv
module nbs_seq
   import nbs_pkg::*;
#(
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [LW-1:0] len_turn,
   input  logic [LW-1:0] len_setup,
   input  logic [LW-1:0] len_wait,
   input  logic [LW-1:0] len_hold,
   input  logic          wait_en,
   input  logic          rdy,
   output nbs_phase_e    phase,
   output logic          req_ready,
   output logic          acc,
   output logic          wait_end,
   output logic          done
);
   logic [LW-1:0] rem, s_q, w_q, h_q;
   logic          stall;

   assign req_ready = (phase == PH_IDLE);
   assign acc       = req_valid && req_ready;
   assign stall     = wait_en && !rdy;
   assign wait_end  = (phase == PH_WAIT) && (rem == '0) && !stall;
   assign done      = (phase == PH_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         rem   <= '0;
         s_q   <= '0;
         w_q   <= '0;
         h_q   <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (acc) begin
               s_q <= len_setup;
               w_q <= len_wait;
               h_q <= len_hold;
               if (len_turn != '0) begin
                  phase <= PH_TURN;
                  rem   <= len_turn - LW'(1);
               end else begin
                  phase <= PH_SETUP;
                  rem   <= len_setup - LW'(1);
               end
            end
            PH_TURN: if (rem == '0) begin
               phase <= PH_SETUP;
               rem   <= s_q - LW'(1);
            end else rem <= rem - LW'(1);
            PH_SETUP: if (rem == '0) begin
               phase <= PH_WAIT;
               rem   <= w_q - LW'(1);
            end else rem <= rem - LW'(1);
            PH_WAIT: if (rem != '0) rem <= rem - LW'(1);
               else if (!stall) begin
                  phase <= PH_HOLD;
                  rem   <= h_q - LW'(1);
               end
            PH_HOLD: if (rem == '0) phase <= PH_DONE;
               else rem <= rem - LW'(1);
            PH_DONE: phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R7
   stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && rem == '0 && stall) |=> (phase == PH_WAIT));

   // R2
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   hold_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HOLD && rem == '0) |=> done);

endmodule

// File: rtl/nbs_pins.sv
module nbs_pins
   import nbs_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  nbs_phase_e        phase,
   input  logic              acc,
   input  nbs_kind_e         req_kind,
   input  logic              req_byte,
   input  logic [DW-1:0]     req_wdata,
   input  logic              bus16,
   input  logic              wait_end,
   input  logic [DW-1:0]     dq_in,
   output logic              ce_n,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [DW-1:0]     dq_out,
   output logic [DW/8-1:0]   dq_oe,
   output logic [DW-1:0]     rd_data
);
   localparam int LANES = DW / 8;

   generate
      if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
         $error("nbs_pins: DW must be a multiple of 8");
      end
   endgenerate

   nbs_kind_e     kind_q;
   logic          narrow_q;
   logic [DW-1:0] wdata_q, lane_mask;
   logic          active, drive, strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q   <= K_WR;
         narrow_q <= 1'b1;
         wdata_q  <= '0;
      end else if (acc) begin
         kind_q   <= req_kind;
         narrow_q <= !bus16 || req_byte;
         wdata_q  <= req_wdata;
      end
   end

   assign active = (phase == PH_TURN) || (phase == PH_SETUP) ||
                   (phase == PH_WAIT) || (phase == PH_HOLD);
   assign drive  = kind_drives(kind_q) &&
                   ((phase == PH_SETUP) || (phase == PH_WAIT) || (phase == PH_HOLD));
   assign strobe = (phase == PH_WAIT);

   assign ce_n = !active;
   assign cle  = active && (kind_q == K_CMD);
   assign ale  = active && (kind_q == K_ADDR);
   assign we_n = !(strobe && kind_drives(kind_q));
   assign re_n = !(strobe && !kind_drives(kind_q));

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         if (l == 0) begin : g_low
            assign lane_mask[7:0] = 8'hFF;
            assign dq_oe[0]       = drive;
         end else begin : g_high
            assign lane_mask[l*8 +: 8] = {8{!narrow_q}};
            assign dq_oe[l]            = drive && !narrow_q;
         end
      end
   endgenerate

   assign dq_out = drive ? (wdata_q & lane_mask) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else if (wait_end && kind_q == K_RD) rd_data <= dq_in & lane_mask;
   end

   // R2
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));

   // R6
   oe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe != '0) |-> !ce_n);

   // R3
   cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));

endmodule

// File: rtl/nbs_nand_seq.sv
module nbs_nand_seq
   import nbs_pkg::*;
#(
   parameter int DW        = 16,
   parameter int FW        = 8,
   parameter int DLYW      = 4,
   parameter int RST_FIELD = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic              req_byte,
   input  logic [DW-1:0]     req_wdata,
   input  logic              bus16,
   input  logic              wait_en,
   input  logic              rdy,
   input  logic              cfg_we,
   input  logic [4*FW-1:0]   cfg_mem,
   input  logic [4*FW-1:0]   cfg_att,
   input  logic [DLYW-1:0]   cfg_cle_re,
   input  logic [DLYW-1:0]   cfg_ale_re,
   output logic              ce_n,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [DW-1:0]     dq_out,
   output logic [DW/8-1:0]   dq_oe,
   input  logic [DW-1:0]     dq_in,
   output logic [DW-1:0]     rd_data,
   output logic              done
);
   localparam int LW = (FW > DLYW + 1) ? FW : DLYW + 1;

   nbs_kind_e     kind;
   nbs_phase_e    phase;
   logic [LW-1:0] len_turn, len_setup, len_wait, len_hold;
   logic          acc, wait_end;

   assign kind = nbs_kind_e'(req_kind);

   nbs_cfg #(.FW(FW), .DLYW(DLYW), .LW(LW), .RST_FIELD(RST_FIELD)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mem(cfg_mem),
      .cfg_att(cfg_att), .cfg_cle_re(cfg_cle_re), .cfg_ale_re(cfg_ale_re),
      .req_kind(kind), .acc(acc), .len_turn(len_turn), .len_setup(len_setup),
      .len_wait(len_wait), .len_hold(len_hold)
   );

   nbs_seq #(.LW(LW)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .len_turn(len_turn),
      .len_setup(len_setup), .len_wait(len_wait), .len_hold(len_hold),
      .wait_en(wait_en), .rdy(rdy), .phase(phase), .req_ready(req_ready),
      .acc(acc), .wait_end(wait_end), .done(done)
   );

   nbs_pins #(.DW(DW)) u_pins (
      .clk(clk), .rst_n(rst_n), .phase(phase), .acc(acc), .req_kind(kind),
      .req_byte(req_byte), .req_wdata(req_wdata), .bus16(bus16),
      .wait_end(wait_end), .dq_in(dq_in), .ce_n(ce_n), .cle(cle), .ale(ale),
      .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe),
      .rd_data(rd_data)
   );

   // R10
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n || done) |-> !req_ready);

endmodule

// File: tb/nbs_nand_seq_test.sv
module nbs_nand_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_ready;
   logic [1:0]  req_kind = '0;
   logic        req_byte = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        bus16 = 1'b0, wait_en = 1'b0, rdy = 1'b1;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_mem = '0, cfg_att = '0;
   logic [3:0]  cfg_cle_re = '0, cfg_ale_re = '0;
   logic        ce_n, cle, ale, we_n, re_n, done;
   logic [15:0] dq_out, rd_data;
   logic [15:0] dq_in = '0;
   logic [1:0]  dq_oe;

   int checks = 0, errors = 0;
   logic [31:0] m_mem = 32'h0A0A0A0A, m_att = 32'h0A0A0A0A;
   int m_cle = 15, m_ale = 15, m_prev = 3;

   always #2.5 clk = ~clk;

   nbs_nand_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_byte(req_byte), .req_wdata(req_wdata),
      .bus16(bus16), .wait_en(wait_en), .rdy(rdy), .cfg_we(cfg_we),
      .cfg_mem(cfg_mem), .cfg_att(cfg_att), .cfg_cle_re(cfg_cle_re),
      .cfg_ale_re(cfg_ale_re), .ce_n(ce_n), .cle(cle), .ale(ale),
      .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe),
      .dq_in(dq_in), .rd_data(rd_data), .done(done)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int fld(input logic [31:0] w, input int i);
      return int'(w[i*8 +: 8]);
   endfunction

   function automatic int one(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic set_cfg(input logic [31:0] mem, input logic [31:0] att,
                          input int cle_d, input int ale_d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_mem = mem; cfg_att = att;
      cfg_cle_re = 4'(cle_d); cfg_ale_re = 4'(ale_d);
      @(negedge clk);
      cfg_we = 1'b0;
      m_mem = mem; m_att = att; m_cle = cle_d; m_ale = ale_d;
   endtask

   // kind: 0 cmd, 1 addr, 2 read, 3 write; k = busy cycles at strobe start
   task automatic access(input string tag, input int kind, input bit byt,
                         input logic [15:0] data, input int k,
                         input bit inject_req, input bit cfg_mid);
      logic [31:0] w;
      int t, s, wt, h, weff, ext, n, ce_cnt, st_cnt, oe_cnt, first_oe;
      bit narrow, drv, seen;
      logic [15:0] mask, pat;
      int oe_at, out_at, cle_at, ale_at;
      w = (kind < 2) ? m_att : m_mem;
      drv = (kind != 2);
      t = drv ? fld(w, 3) : 0;
      ext = 0;
      if (kind == 2 && m_prev == 0) ext = m_cle + 1;
      if (kind == 2 && m_prev == 1) ext = m_ale + 1;
      s = imax(one(fld(w, 0)), ext);
      wt = one(fld(w, 1));
      h = one(fld(w, 2));
      weff = wait_en ? imax(wt, k + 1) : wt;
      narrow = !bus16 || byt;
      mask = narrow ? 16'h00FF : 16'hFFFF;
      pat = 16'($urandom);
      n = 0; ce_cnt = 0; st_cnt = 0; oe_cnt = 0; first_oe = -1; seen = 0;
      oe_at = 0; out_at = 0; cle_at = 0; ale_at = 0;
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'(kind); req_byte = byt; req_wdata = data;
      @(negedge clk);
      req_valid = 1'b0;
      while (n < 3000) begin
         n++;
         if (inject_req && n == 2) begin req_valid = 1'b1; req_kind = 2'd3; end
         if (inject_req && n == 3) req_valid = 1'b0;
         if (cfg_mid && n == 2) begin
            cfg_we = 1'b1; cfg_mem = 32'h01020301; cfg_att = 32'h00010101;
            cfg_cle_re = 4'd2; cfg_ale_re = 4'd2;
         end
         if (cfg_mid && n == 3) cfg_we = 1'b0;
         if (done) break;
         if (dq_oe != 2'b00) begin
            if (first_oe < 0) first_oe = ce_cnt;
            oe_cnt++;
         end
         if (!ce_n) ce_cnt++;
         if ((drv && !we_n) || (!drv && !re_n)) begin
            if (!seen) begin
               seen = 1; oe_at = int'(dq_oe); out_at = int'(dq_out);
               cle_at = int'(cle); ale_at = int'(ale);
            end
            rdy = (st_cnt >= k);
            st_cnt++;
         end else rdy = 1'b1;
         dq_in = !re_n ? pat : ~pat;
         @(negedge clk);
      end
      rdy = 1'b1;
      if (cfg_mid) begin
         m_mem = 32'h01020301; m_att = 32'h00010101; m_cle = 2; m_ale = 2;
      end
      chk(tag, "cycles to done", n, t + s + weff + h + 1);
      chk(tag, "ce_n low cycles", ce_cnt, t + s + weff + h);
      chk(tag, "strobe low cycles", st_cnt, weff);
      chk("R6", "bus driven cycles", oe_cnt, drv ? s + weff + h : 0);
      if (drv) chk("R6", "release cycles before drive", first_oe, t);
      chk("R3", "cle during strobe", cle_at, kind == 0 ? 1 : 0);
      chk("R3", "ale during strobe", ale_at, kind == 1 ? 1 : 0);
      if (drv) begin
         chk("R9", "lane enables", oe_at, narrow ? 1 : 3);
         chk("R9", "bus data", out_at, int'(data & mask));
      end else begin
         chk("R8", "read capture", int'(rd_data), int'(pat & mask));
      end
      m_prev = kind;
      @(negedge clk);
      chk("R10", "ready after access", int'(req_ready), 1);
      if (inject_req) begin
         @(negedge clk);
         chk("R10", "no access from busy request", int'(ce_n), 1);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL R2 watchdog actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      #12 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "ce_n", int'(ce_n), 1);
      chk("R1", "we_n re_n", int'({we_n, re_n}), 3);
      chk("R1", "cle ale oe", int'({cle, ale, dq_oe}), 0);
      chk("R1", "req_ready", int'(req_ready), 1);
      // R1 default timing words, R5 default 16-cycle delay after command
      access("R1", 0, 0, 16'h0070, 0, 0, 0);
      access("R5", 2, 0, 16'h0, 0, 0, 0);
      // R4 zero fields clamp to one
      set_cfg(32'h0, 32'h0, 0, 0);
      access("R4", 3, 0, 16'h00A5, 0, 0, 0);
      access("R4", 1, 0, 16'h0012, 0, 0, 0);
      // R5 extensions
      set_cfg(32'h00020201, 32'h01010101, 6, 3);
      access("R5", 0, 0, 16'h0005, 0, 0, 0);
      access("R5", 2, 0, 16'h0, 0, 0, 0);
      access("R5", 1, 0, 16'h0033, 0, 0, 0);
      access("R5", 2, 0, 16'h0, 0, 0, 0);
      access("R5", 3, 0, 16'h0044, 0, 0, 0);
      access("R5", 2, 0, 16'h0, 0, 0, 0);
      // R7 busy stretch, enabled and ignored
      wait_en = 1'b1;
      access("R7", 2, 0, 16'h0, 5, 0, 0);
      access("R7", 3, 0, 16'h0077, 1, 0, 0);
      wait_en = 1'b0;
      access("R7", 2, 0, 16'h0, 5, 0, 0);
      // R9 widths
      bus16 = 1'b1;
      access("R9", 3, 0, 16'hBEEF, 0, 0, 0);
      access("R9", 2, 0, 16'h0, 0, 0, 0);
      access("R9", 3, 1, 16'hBEEF, 0, 0, 0);
      access("R9", 2, 1, 16'h0, 0, 0, 0);
      // R10 request during access, R11 config write during access
      set_cfg(32'h02030302, 32'h01020202, 1, 1);
      access("R10", 3, 0, 16'h1234, 0, 1, 0);
      access("R11", 2, 0, 16'h0, 0, 0, 1);
      access("R11", 2, 0, 16'h0, 0, 0, 0);
      // random mix
      for (int i = 0; i < 60; i++) begin
         if (i % 6 == 0)
            set_cfg({6'd0, 2'($urandom), 5'd0, 3'($urandom), 5'd0, 3'($urandom), 5'd0, 3'($urandom)},
                    {6'd0, 2'($urandom), 5'd0, 3'($urandom), 5'd0, 3'($urandom), 5'd0, 3'($urandom)},
                    int'($urandom % 16), int'($urandom % 16));
         bus16   = 1'($urandom);
         wait_en = 1'($urandom);
         access("R2", int'($urandom % 4), 1'($urandom), 16'($urandom), int'($urandom % 6), 0, 0);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule